// File: doc/BRIEF.md
# Power-Good Asymmetric Deglitch Filter

This block decides the power-good status of one regulator channel. It compares a sampled feedback code against a window of plus and minus ten percent around a reference code. It then qualifies every change of status with a clock-cycle timer. A fault must last without a break for a long entry interval before power-good drops. After a fault, the feedback must stay inside the window for a shorter exit interval before power-good returns.

Three hard conditions bypass the entry timer and pull the status low at the next clock edge: run disabled, undervoltage lockout and over-temperature. When they clear, the normal exit qualification still applies. The result drives an open-drain stage through a registered pull-down enable. After reset the channel starts as faulted, so the first assertion always waits the full exit interval.

The two intervals are parameters in clock cycles. At 250 MHz, 130 us is 32500 cycles and 30 us is 7500 cycles.

Top module: `pwrgood_filter`

## Requirements
- R1: The low limit is REF_CODE - floor(REF_CODE/10) and the high limit is REF_CODE + floor(REF_CODE/10). A code equal to either limit counts as in-window. A code below the low limit or above the high limit is a fault.
- R2: While power-good is high and no override is active, power-good falls at the clock edge that samples the ENTER_CYC-th consecutive out-of-window code.
- R3: While power-good is low and no override is active, power-good rises at the clock edge that samples the EXIT_CYC-th consecutive in-window code.
- R4: The entry timer does not integrate. Any single in-window sample restarts it from zero, so repeated excursions shorter than ENTER_CYC cycles never drop power-good.
- R5: An out-of-window sample during exit qualification restarts the exit timer from zero, and power-good stays low.
- R6: Each of run_en low, uvlo high or ovr_temp high drops power-good at the next clock edge, with no entry delay.
- R7: After all overrides clear, with feedback in-window, power-good rises only after EXIT_CYC consecutive clean cycles.
- R8: During and after reset, power-good is 0 and pd_en is 1. The first assertion after reset needs the full exit qualification.
- R9: pd_en is registered and is always the inverse of power-good. It is 1 when the pin must be pulled low.
- R10: Undervoltage (code below the low limit) and overvoltage (code above the high limit) faults use the same entry and exit delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_code | input | CODE_W | Sampled feedback code |
| run_en | input | 1 | Channel run enable, active high |
| uvlo | input | 1 | Undervoltage lockout active |
| ovr_temp | input | 1 | Over-temperature active |
| pg | output | 1 | Power-good status, active high |
| pd_en | output | 1 | Open-drain pull-down enable |

## Verification
The bench places codes exactly on the low and high limits and checks that power-good holds. A design with an exclusive compare would drop it there. It sends a series of excursions, each one cycle shorter than the entry delay, and expects power-good to stay high. A design that accumulates fault time would trip partway through the series. It also breaks exit qualification with one bad sample and expects the full exit delay to start again, which catches a timer that pauses instead of clearing. For each override source, the bench checks that the output drops after exactly one edge. It then checks that release still waits the full exit interval, which exposes a design that returns power-good as soon as the override goes away.

// File: rtl/pg_pkg.sv
package pg_pkg;

  // Low edge of the in-window band (inclusive).
  function automatic int unsigned uv_limit(input int unsigned ref_code);
    return ref_code - (ref_code / 10);
  endfunction

  // High edge of the in-window band (inclusive).
  function automatic int unsigned ov_limit(input int unsigned ref_code);
    return ref_code + (ref_code / 10);
  endfunction

  // Bits needed to count 0 .. limit.
  function automatic int unsigned timer_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pg_window.sv
module pg_window #(
  parameter int unsigned CODE_W   = 10,
  parameter int unsigned REF_CODE = 400
) (
  input  logic [CODE_W-1:0] code,
  output logic              uv_hit,
  output logic              ov_hit,
  output logic              in_win
);
  localparam int unsigned UV_I = pg_pkg::uv_limit(REF_CODE);
  localparam int unsigned OV_I = pg_pkg::ov_limit(REF_CODE);
  localparam logic [CODE_W:0] UV_C = (CODE_W+1)'(UV_I);
  localparam logic [CODE_W:0] OV_C = (CODE_W+1)'(OV_I);

  logic [CODE_W:0] code_x;
  assign code_x = {1'b0, code};

  always_comb begin
    uv_hit = (code_x < UV_C);
    ov_hit = (code_x > OV_C);
    in_win = !(uv_hit || ov_hit);
  end

  // R1: the band is never empty, so both limits cannot be crossed at once
  always_comb begin
    assert_uv_ov_exclusive_R1: assert (!(uv_hit && ov_hit));
  end

endmodule

// File: rtl/pg_qual_timer.sv
module pg_qual_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned W = pg_pkg::timer_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] TOP  = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    done  = run && (cnt_q == LAST);
    cnt_d = (!run || done) ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4/R5: the count never passes the expiry value
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < TOP);

  // R4/R5: a stop in the run condition clears the count (no accumulation)
  assert_clear_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/pwrgood_filter.sv
module pwrgood_filter #(
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned REF_CODE  = 400,
  parameter int unsigned ENTER_CYC = 32500,
  parameter int unsigned EXIT_CYC  = 7500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] fb_code,
  input  logic              run_en,
  input  logic              uvlo,
  input  logic              ovr_temp,
  output logic              pg,
  output logic              pd_en
);
  logic uv_hit, ov_hit, in_win;
  logic force_low;
  logic enter_run, exit_run;
  logic enter_done, exit_done;
  logic good_q, good_d;
  logic pd_q;

  pg_window #(.CODE_W(CODE_W), .REF_CODE(REF_CODE)) u_win (
    .code   (fb_code),
    .uv_hit (uv_hit),
    .ov_hit (ov_hit),
    .in_win (in_win)
  );

  assign force_low = !run_en || uvlo || ovr_temp;
  assign enter_run = good_q && !in_win && !force_low;
  assign exit_run  = !good_q && in_win && !force_low;

  pg_qual_timer #(.LIMIT(ENTER_CYC)) u_enter (
    .clk (clk), .rst_n (rst_n), .run (enter_run), .done (enter_done)
  );

  pg_qual_timer #(.LIMIT(EXIT_CYC)) u_exit (
    .clk (clk), .rst_n (rst_n), .run (exit_run), .done (exit_done)
  );

  always_comb begin
    good_d = good_q;
    if (force_low)                 good_d = 1'b0;
    else if (good_q && enter_done) good_d = 1'b0;
    else if (!good_q && exit_done) good_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= 1'b0;
      pd_q   <= 1'b1;
    end else begin
      good_q <= good_d;
      pd_q   <= !good_d;
    end
  end

  assign pg    = good_q;
  assign pd_en = pd_q;

  // R6: any override drops the status at the next edge
  assert_override_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |=> !pg);

  // R3/R7: a rise only follows a completed exit qualification
  assert_rise_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg) |-> $past(exit_done));

  // R2: a fall needs an override or a completed entry qualification
  assert_fall_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg) |-> ($past(force_low) || $past(enter_done)));

  // R4: an in-window sample with no override keeps an asserted status
  assert_hold_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pg && in_win && !force_low) |=> pg);

  // R9: pull-down enable mirrors the status
  assert_pd_inverse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en == !pg);

endmodule

// File: tb/pwrgood_filter_tb.sv
module pwrgood_filter_tb;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned REFC   = 400;
  localparam int unsigned ENTER  = 12;
  localparam int unsigned EXIT   = 5;
  // Limits from R1 restated: 400 - 40 and 400 + 40
  localparam int unsigned LO = 360;
  localparam int unsigned HI = 440;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CODE_W-1:0] fb_code = CODE_W'(REFC);
  logic run_en = 1'b1, uvlo = 1'b0, ovr_temp = 1'b0;
  logic pg, pd_en;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwrgood_filter #(.CODE_W(CODE_W), .REF_CODE(REFC),
                   .ENTER_CYC(ENTER), .EXIT_CYC(EXIT)) u_dut (
    .clk (clk), .rst_n (rst_n), .fb_code (fb_code), .run_en (run_en),
    .uvlo (uvlo), .ovr_temp (ovr_temp), .pg (pg), .pd_en (pd_en)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Full drop from a good state through an out-of-window code
  task automatic drop_with(input int unsigned code, input string req);
    fb_code = CODE_W'(code);
    tick(ENTER - 1);
    chk({req, " pg before entry expiry"}, pg, 1'b1);
    tick(1);
    chk({req, " pg at entry expiry"}, pg, 1'b0);
    chk("R9 pd_en while faulted", pd_en, 1'b1);
  endtask

  task automatic recover(input string req);
    fb_code = CODE_W'(REFC);
    tick(EXIT - 1);
    chk({req, " pg before exit expiry"}, pg, 1'b0);
    tick(1);
    chk({req, " pg at exit expiry"}, pg, 1'b1);
    chk("R9 pd_en while good", pd_en, 1'b0);
  endtask

  task automatic test_reset;
    chk("R8 pg in reset", pg, 1'b0);
    chk("R8 pd_en in reset", pd_en, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    recover("R8");
  endtask

  task automatic test_uv_ov;
    drop_with(LO - 1, "R2 R10 undervoltage");
    recover("R3");
    drop_with(HI + 1, "R2 R10 overvoltage");
    recover("R3");
  endtask

  task automatic test_limits;
    fb_code = CODE_W'(LO);
    tick(ENTER + 3);
    chk("R1 code at low limit", pg, 1'b1);
    fb_code = CODE_W'(HI);
    tick(ENTER + 3);
    chk("R1 code at high limit", pg, 1'b1);
    fb_code = CODE_W'(REFC);
    tick(1);
  endtask

  task automatic test_no_integrate;
    for (int i = 0; i < 4; i++) begin
      fb_code = CODE_W'((i % 2 == 0) ? LO - 5 : HI + 5);
      tick(ENTER - 1);
      fb_code = CODE_W'(REFC);
      tick(1);
      chk("R4 short excursion ignored", pg, 1'b1);
    end
  endtask

  task automatic test_exit_restart;
    drop_with(LO - 1, "R2");
    fb_code = CODE_W'(REFC);
    tick(EXIT - 1);
    fb_code = CODE_W'(HI + 1);
    tick(1);
    chk("R5 re-fault keeps pg low", pg, 1'b0);
    recover("R5 exit timer restarted");
  endtask

  task automatic test_overrides;
    for (int s = 0; s < 3; s++) begin
      tick(2);
      if (s == 0) run_en = 1'b0;
      else if (s == 1) uvlo = 1'b1;
      else ovr_temp = 1'b1;
      tick(1);
      chk("R6 override drops pg in one edge", pg, 1'b0);
      chk("R9 pd_en under override", pd_en, 1'b1);
      tick(EXIT + 2);
      chk("R6 pg held low while override", pg, 1'b0);
      run_en = 1'b1; uvlo = 1'b0; ovr_temp = 1'b0;
      recover("R7");
    end
  endtask

  initial begin
    tick(3);
    test_reset();
    test_uv_ov();
    test_limits();
    test_no_integrate();
    test_exit_restart();
    test_overrides();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule